// File: doc/BRIEF.md
# Reset Mode Latch and Write Guard

This block captures a three-bit operating mode from dedicated mode pins while reset is asserted and holds it after release. The captured mode selects which decoded flags are raised (special, expanded, wide, single chip) and whether background debug is active out of reset. It also picks the reset value of a five-bit port-function configuration register.

After reset, software may try to rewrite the mode field and the port-function register through one write port. `wrSel` chooses the target register. The block decides whether each write is taken. That decision depends on the current mode, on a forbidden mode code, and on a per-field record of earlier writes. The block holds the configuration state only. Pin multiplexing, clock generation and the processor sit outside it.

Top module: `modeLatch`

## Requirements
- R1: Reset is synchronous and active low (`rstN`). While `rstN` is low, `curMode` loads `modePins` on every clock edge. Once `rstN` is high, changes on `modePins` have no effect, and `curMode` changes only through an accepted mode write.
- R2: Mode codes are 000 special single chip, 001 emulation narrow, 010 special test, 011 emulation wide, 100 normal single chip, 101 normal narrow, 110 peripheral and 111 normal wide. The flags decode from `curMode` as follows:
  - `isSpecial` is set when bit 2 is 0.
  - `isSingleChip` is set when bits [1:0] are 00.
  - `isExpanded` is set when bit 0 is 1 or the mode is 010.
  - `isWide` is set when `isExpanded` is set and bit 1 is 1.
- R3: `bdmAtReset` is 1 exactly when the mode latched during reset is 000. Later mode writes do not change it.
- R4: In modes 000 and 010, a mode write (`wrEn`=1, `wrSel`=0) loads `wrData[2:0]` one clock later. This holds for any number of writes.
- R5: A mode write whose resulting mode would be 110 is ignored in every mode.
- R6: In mode 100, a mode write keeps bit 2 at 1 and takes only `wrData[1:0]`. Only the first accepted write after reset takes effect. A write rejected under R5 does not use up that single write.
- R7: In modes 001, 011, 101, 110 and 111, mode writes are ignored.
- R8: `portCfg` bits are [0] direction output, [1] byte strobe output, [2] E-clock off, [3] pipe status output and [4] free-cycle output. Its reset value by latched mode is:

  | Latched mode | `portCfg` reset value |
  |---|---|
  | 000, 100, 110 | 0x04 |
  | 001 | 0x19 |
  | 010, 111 | 0x03 |
  | 011 | 0x1B |
  | 101 | 0x01 |

- R9: A configuration write (`wrEn`=1, `wrSel`=1) updates bit i of `portCfg` to `wrData[i]` only when `wrMask[i]` is 1. Bits 0, 1, 3 and 4 each accept only their first masked write after reset, even if that write leaves the value unchanged.
- R10: Bit 2 of `portCfg` accepts every masked write.
- R11: While the mode is 010, bits 0, 1, 3 and 4 of `portCfg` accept every masked write.
- R12: A mode write leaves `portCfg` unchanged, a configuration write leaves `curMode` unchanged, and nothing changes while `wrEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; the mode is sampled while it is low |
| modePins | input | 3 | Mode pin levels {C,B,A} |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 1 | Target select: 0 selects the mode field, 1 selects the port configuration |
| wrData | input | 5 | Write data (bits [2:0] are used for mode writes) |
| wrMask | input | 5 | Per-bit enable for configuration writes |
| curMode | output | 3 | Current mode |
| isSpecial | output | 1 | Special or emulation mode |
| isExpanded | output | 1 | External bus mode |
| isWide | output | 1 | 16-bit external data bus |
| isSingleChip | output | 1 | No external bus |
| bdmAtReset | output | 1 | Background debug active out of reset |
| portCfg | output | 5 | Port-function configuration bits |

## Verification
The bench uses the default parameters, so the E-clock bit is the only always-writable field and special test is the mode that lifts the write-once rule. With these defaults, every latched mode code can be reached through a reset with different pin levels. That covers each write-rights class: free, once-only and read-only. It also covers the forbidden 110 result in the modes where writes are otherwise free. Directed sequences then exercise the lock state: a rejected write that does not consume the single normal-mode write, per-bit locking under partial masks, and repeated configuration writes in special test mode.

// File: rtl/modeLatchPkg.sv
package modeLatchPkg;

  localparam int MODE_W = 3;
  localparam int CFG_W  = 5;

  typedef enum logic [MODE_W-1:0] {
    MODE_SPC_SINGLE = 3'b000,
    MODE_EMU_NARROW = 3'b001,
    MODE_SPC_TEST   = 3'b010,
    MODE_EMU_WIDE   = 3'b011,
    MODE_NRM_SINGLE = 3'b100,
    MODE_NRM_NARROW = 3'b101,
    MODE_PERIPH     = 3'b110,
    MODE_NRM_WIDE   = 3'b111
  } opMode_e;

  localparam logic [MODE_W-1:0] MODE_FORBIDDEN = MODE_PERIPH;

  // Positions of the port-function configuration bits
  localparam int CFG_DIR      = 0;
  localparam int CFG_STROBE   = 1;
  localparam int CFG_ECLK_OFF = 2;
  localparam int CFG_PIPE     = 3;
  localparam int CFG_FREE     = 4;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic              modeLoad;
    logic [MODE_W-1:0] modeVal;
    logic [CFG_W-1:0]  cfgLoad;
  } strobe_t;

  // Reset value of the port configuration for a latched mode
  function automatic logic [CFG_W-1:0] cfgResetValue(input logic [MODE_W-1:0] m);
    logic [CFG_W-1:0] v;
    v = '0;
    case (m)
      MODE_EMU_NARROW: begin
        v[CFG_FREE] = 1'b1; v[CFG_PIPE] = 1'b1; v[CFG_DIR] = 1'b1;
      end
      MODE_EMU_WIDE: begin
        v[CFG_FREE] = 1'b1; v[CFG_PIPE] = 1'b1;
        v[CFG_STROBE] = 1'b1; v[CFG_DIR] = 1'b1;
      end
      MODE_SPC_TEST, MODE_NRM_WIDE: begin
        v[CFG_STROBE] = 1'b1; v[CFG_DIR] = 1'b1;
      end
      MODE_NRM_NARROW: v[CFG_DIR] = 1'b1;
      default: v[CFG_ECLK_OFF] = 1'b1;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/modeLatchCtrl.sv
module modeLatchCtrl
  import modeLatchPkg::*;
#(
  parameter logic [CFG_W-1:0] ANYTIME_MASK = 5'b00100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [MODE_W-1:0] wrModeData,
  input  logic [CFG_W-1:0]  wrMask,
  input  logic [MODE_W-1:0] curMode,
  output strobe_t           strobes
);

  logic             modeOnce;
  logic [CFG_W-1:0] cfgOnce;
  logic [CFG_W-1:0] cfgLoadVec;
  logic             modeWrite;
  logic             cfgWrite;
  logic             inTest;
  logic [MODE_W-1:0] nrmCandidate;

  assign modeWrite    = wrEn & ~wrSel;
  assign cfgWrite     = wrEn & wrSel;
  assign inTest       = (curMode == MODE_SPC_TEST);
  assign nrmCandidate = {1'b1, wrModeData[1:0]};

  // Per-field acceptance of configuration writes
  for (genvar i = 0; i < CFG_W; i++) begin : g_cfgField
    if (ANYTIME_MASK[i]) begin : g_anytime
      assign cfgLoadVec[i] = cfgWrite & wrMask[i];
    end else begin : g_once
      assign cfgLoadVec[i] = cfgWrite & wrMask[i] & (inTest | ~cfgOnce[i]);
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.cfgLoad  = cfgLoadVec;
    if (modeWrite) begin
      case (curMode)
        MODE_SPC_SINGLE, MODE_SPC_TEST: begin
          if (wrModeData != MODE_FORBIDDEN) begin
            strobes.modeLoad = 1'b1;
            strobes.modeVal  = wrModeData;
          end
        end
        MODE_NRM_SINGLE: begin
          if (!modeOnce && nrmCandidate != MODE_FORBIDDEN) begin
            strobes.modeLoad = 1'b1;
            strobes.modeVal  = nrmCandidate;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeOnce <= 1'b0;
      cfgOnce  <= '0;
    end else begin
      if (strobes.modeLoad && curMode == MODE_NRM_SINGLE) modeOnce <= 1'b1;
      cfgOnce <= cfgOnce | cfgLoadVec;
    end
  end

  // R9: a taken configuration write locks its field from the next cycle on
  p_once_locks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoadVec != '0) |=> ((cfgOnce & $past(cfgLoadVec)) == $past(cfgLoadVec)));

  // R6: no second mode load in normal single chip once the single write is used
  p_single_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeOnce && curMode == MODE_NRM_SINGLE) |-> !strobes.modeLoad);

  // R12: nothing is loaded without a write strobe
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (!strobes.modeLoad && strobes.cfgLoad == '0));

endmodule

// File: rtl/modeLatchData.sv
module modeLatchData
  import modeLatchPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modePins,
  input  logic [CFG_W-1:0]  wrCfgData,
  input  strobe_t           strobes,
  output logic [MODE_W-1:0] curMode,
  output logic              bdmAtReset,
  output logic [CFG_W-1:0]  portCfg,
  output logic              isSpecial,
  output logic              isExpanded,
  output logic              isWide,
  output logic              isSingleChip
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode    <= modePins;
      bdmAtReset <= (modePins == MODE_SPC_SINGLE);
      portCfg    <= cfgResetValue(modePins);
    end else begin
      if (strobes.modeLoad) curMode <= strobes.modeVal;
      portCfg <= (portCfg & ~strobes.cfgLoad) | (wrCfgData & strobes.cfgLoad);
    end
  end

  always_comb begin
    isSpecial    = ~curMode[2];
    isSingleChip = (curMode[1:0] == 2'b00);
    isExpanded   = curMode[0] | (curMode == MODE_SPC_TEST);
    isWide       = isExpanded & curMode[1];
  end

  // R5: a write never produces the forbidden mode
  p_no_forbidden_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.modeLoad |=> (curMode != MODE_FORBIDDEN));

  // R7: read-only modes keep their value
  p_ro_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (curMode inside {MODE_EMU_NARROW, MODE_EMU_WIDE, MODE_NRM_NARROW,
                     MODE_PERIPH, MODE_NRM_WIDE}) |=> $stable(curMode));

  // R1: after release the mode moves only on a load
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.modeLoad |=> $stable(curMode));

  // R3: debug flag fixed outside reset
  p_bdm_fixed_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(bdmAtReset));

  // R2: single chip and expanded are exclusive; wide implies expanded
  p_flags_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({isSingleChip, isExpanded}) && (!isWide || isExpanded));

  // R9: configuration holds without load strobes
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cfgLoad == '0) |=> $stable(portCfg));

endmodule

// File: rtl/modeLatch.sv
module modeLatch
  import modeLatchPkg::*;
#(
  parameter logic [CFG_W-1:0] ANYTIME_MASK = 5'b00100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modePins,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [CFG_W-1:0]  wrData,
  input  logic [CFG_W-1:0]  wrMask,
  output logic [MODE_W-1:0] curMode,
  output logic              isSpecial,
  output logic              isExpanded,
  output logic              isWide,
  output logic              isSingleChip,
  output logic              bdmAtReset,
  output logic [CFG_W-1:0]  portCfg
);

  strobe_t strobes;

  modeLatchCtrl #(.ANYTIME_MASK(ANYTIME_MASK)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrModeData (wrData[MODE_W-1:0]),
    .wrMask     (wrMask),
    .curMode    (curMode),
    .strobes    (strobes)
  );

  modeLatchData i_data (
    .clk          (clk),
    .rstN         (rstN),
    .modePins     (modePins),
    .wrCfgData    (wrData),
    .strobes      (strobes),
    .curMode      (curMode),
    .bdmAtReset   (bdmAtReset),
    .portCfg      (portCfg),
    .isSpecial    (isSpecial),
    .isExpanded   (isExpanded),
    .isWide       (isWide),
    .isSingleChip (isSingleChip)
  );

endmodule

// File: tb/test_modeLatch.sv
`timescale 1ns/1ps
module test_modeLatch;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modePins = 3'b000;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [4:0] wrData = '0;
  logic [4:0] wrMask = '0;
  logic [2:0] curMode;
  logic       isSpecial, isExpanded, isWide, isSingleChip, bdmAtReset;
  logic [4:0] portCfg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  modeLatch i_modeLatch (
    .clk(clk), .rstN(rstN), .modePins(modePins), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .wrMask(wrMask), .curMode(curMode), .isSpecial(isSpecial),
    .isExpanded(isExpanded), .isWide(isWide), .isSingleChip(isSingleChip),
    .bdmAtReset(bdmAtReset), .portCfg(portCfg)
  );

  // {pins, write data, expected mode, expected reset portCfg}
  localparam logic [13:0] VEC [12] = '{
    {3'b000, 3'b101, 3'b101, 5'h04},
    {3'b000, 3'b110, 3'b000, 5'h04},
    {3'b010, 3'b111, 3'b111, 5'h03},
    {3'b010, 3'b110, 3'b010, 5'h03},
    {3'b100, 3'b011, 3'b111, 5'h04},
    {3'b100, 3'b010, 3'b100, 5'h04},
    {3'b100, 3'b001, 3'b101, 5'h04},
    {3'b001, 3'b000, 3'b001, 5'h19},
    {3'b011, 3'b000, 3'b011, 5'h1B},
    {3'b101, 3'b000, 3'b101, 5'h01},
    {3'b110, 3'b000, 3'b110, 5'h04},
    {3'b111, 3'b000, 3'b111, 5'h03}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Flag decode per R2: {special, expanded, wide, singleChip}
  function automatic logic [3:0] expFlags(input logic [2:0] m);
    logic ex;
    ex = (m == 3'b001) || (m == 3'b011) || (m == 3'b101) || (m == 3'b111) || (m == 3'b010);
    return {(m < 3'b100), ex, ex && (m == 3'b011 || m == 3'b111 || m == 3'b010),
            (m == 3'b000 || m == 3'b100)};
  endfunction

  task automatic doReset(input logic [2:0] pins);
    @(negedge clk);
    modePins = pins;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doWrite(input logic sel, input logic [4:0] data, input logic [4:0] mask);
    wrEn = 1'b1; wrSel = sel; wrData = data; wrMask = mask;
    @(negedge clk);
    wrEn = 1'b0; wrMask = '0;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    string tag;
    // Table walk over every latched mode
    for (int k = 0; k < 12; k++) begin
      doReset(VEC[k][13:11]);
      chk("R8 reset portCfg", {3'b0, portCfg}, {3'b0, VEC[k][4:0]});
      chk("R2 flags", {4'b0, isSpecial, isExpanded, isWide, isSingleChip},
          {4'b0, expFlags(VEC[k][13:11])});
      chk("R3 bdm flag", {7'b0, bdmAtReset}, {7'b0, VEC[k][13:11] == 3'b000});
      doWrite(1'b0, {2'b0, VEC[k][10:8]}, 5'h00);
      if (VEC[k][13:11] == 3'b100) tag = "R6 normal write";
      else if (VEC[k][13:11] == 3'b000 || VEC[k][13:11] == 3'b010)
        tag = (VEC[k][10:8] == 3'b110) ? "R5 forbidden write" : "R4 free write";
      else tag = "R7 read-only write";
      chk(tag, {5'b0, curMode}, {5'b0, VEC[k][7:5]});
    end

    // R1: tracking during reset, hold after release
    @(negedge clk);
    rstN = 1'b0; modePins = 3'b001;
    @(negedge clk);
    chk("R1 track in reset", {5'b0, curMode}, 8'h01);
    modePins = 3'b100;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    modePins = 3'b000;
    @(negedge clk);
    @(negedge clk);
    chk("R1 hold after release", {5'b0, curMode}, 8'h04);

    // R6: rejected write does not consume, second accepted write ignored
    doWrite(1'b0, 5'b00010, 5'h00);
    chk("R6 reject 10", {5'b0, curMode}, 8'h04);
    doWrite(1'b0, 5'b00001, 5'h00);
    chk("R6 first write", {5'b0, curMode}, 8'h05);
    doWrite(1'b0, 5'b00011, 5'h00);
    chk("R6 second write ignored", {5'b0, curMode}, 8'h05);

    // R4 repeated writes and R3 flag stays after mode change
    doReset(3'b000);
    doWrite(1'b0, 5'b00010, 5'h00);
    chk("R4 to test", {5'b0, curMode}, 8'h02);
    doWrite(1'b0, 5'b00100, 5'h00);
    chk("R4 to normal single", {5'b0, curMode}, 8'h04);
    chk("R3 bdm kept", {7'b0, bdmAtReset}, 8'h01);
    // R12: configuration write leaves mode; idle strobe changes nothing
    doWrite(1'b1, 5'h1F, 5'h02);
    chk("R12 mode untouched", {5'b0, curMode}, 8'h04);
    chk("R9 first masked write", {3'b0, portCfg}, 8'h06);
    wrData = 5'h00; wrMask = 5'h1F; wrSel = 1'b1;
    @(negedge clk);
    chk("R12 idle no change", {3'b0, portCfg}, 8'h06);

    // R9 / R10: per-field locking in normal single chip
    doReset(3'b100);
    doWrite(1'b1, 5'h1F, 5'h01);
    chk("R9 dir set", {3'b0, portCfg}, 8'h05);
    doWrite(1'b1, 5'h00, 5'h1F);
    chk("R9 lock per field", {3'b0, portCfg}, 8'h01);
    doWrite(1'b1, 5'h1F, 5'h1F);
    chk("R10 eclk anytime", {3'b0, portCfg}, 8'h05);
    doWrite(1'b0, 5'b00011, 5'h00);
    chk("R12 mode write keeps cfg", {3'b0, portCfg}, 8'h05);

    // R11: special test lifts write-once
    doReset(3'b010);
    doWrite(1'b1, 5'h1F, 5'h1F);
    chk("R11 first", {3'b0, portCfg}, 8'h1F);
    doWrite(1'b1, 5'h00, 5'h1F);
    chk("R11 repeat", {3'b0, portCfg}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule